// File: doc/BRIEF.md
# Dual-Ratio Clock Strobe Generator

This block turns one fast reference tick stream into clock-enable strobes for two domains: a system bus domain and a high-speed peripheral domain. It has two sources. On the oscillator source every reference tick is a double-rate system strobe, and the high-speed strobe stays off. On the PLL source two divider counters run side by side on the same ticks. One divides by two to make the high-speed strobe. The other divides by three to make the double-rate system strobe. A further halving of the double-rate strobe gives the 1x bus strobe, so on the PLL source the high-speed domain runs at exactly three times the bus rate.

A source change does not take effect at once. It is held until every divider counter is at zero. Downstream of the dividers, the timer and the PWM each have a select bit. That bit picks either the 1x strobe or the 3x strobe for the block. Every peripheral enable, including a parameterised group of general peripherals that always run at 1x, can be stalled by its own input. A stall does not touch the dividers. All strobes are registered, so each one appears one clock after the reference tick that causes it.

Top module: `clksel_div`

## Requirements
- R1: While `rst_n` is low, every output is 0, all divider counters are 0 and the oscillator source is active.
- R2: On the PLL source (`src_pll`=1), `hs_en` pulses on every second reference tick, counted from the point where the counters were at zero.
- R3: On the PLL source, `x2_en` pulses on every third reference tick.
- R4: `bus_en` pulses on every second `x2_en` strobe, so on the PLL source `hs_en` pulses exactly three times per `bus_en` pulse.
- R5: On the oscillator source (`src_pll`=0), `x2_en` follows every reference tick and `hs_en` stays 0.
- R6: A change of `src_pll` becomes active only in a cycle in which all divider counters are 0. Until then, the previous source keeps running with unshortened periods.
- R7: With `tmr_fast`=1 (or `pwm_fast`=1), `tmr_en` (or `pwm_en`) follows the high-speed strobe. With the bit at 0, it follows the 1x bus strobe.
- R8: A high stall input forces its peripheral enable to 0 on the next cycle, and the divider phase is left unchanged.
- R9: Each bit of `per_en` follows the 1x bus strobe, gated by the matching bit of `per_stall`.
- R10: Every strobe output is registered and goes high in the clock cycle after the reference tick that produces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference tick, one cycle per reference period |
| src_pll | input | 1 | Source select: 1 = PLL path, 0 = oscillator path |
| tmr_fast | input | 1 | Timer rate select: 1 = 3x, 0 = 1x |
| pwm_fast | input | 1 | PWM rate select: 1 = 3x, 0 = 1x |
| tmr_stall | input | 1 | Timer hold-off |
| pwm_stall | input | 1 | PWM hold-off |
| per_stall | input | N_PER | Hold-off per general peripheral |
| hs_en | output | 1 | High-speed (3x) strobe |
| x2_en | output | 1 | Double-rate system strobe |
| bus_en | output | 1 | 1x system bus strobe |
| tmr_en | output | 1 | Timer clock enable |
| pwm_en | output | 1 | PWM clock enable |
| per_en | output | N_PER | General peripheral clock enables |

## Verification
A divider counter that slips a phase shows up at once as a strobe on the wrong tick. The bench compares every strobe against a behavioural phase model on every clock, so such a fault is reported within one clock of its first effect. A source change taken at the wrong point shows up as a shortened period on `x2_en` or `bus_en`, or as a stray `hs_en`, within six reference ticks. A stall that leaks into the dividers shifts every later `bus_en` pulse, so it appears at the next bus strobe after the stall is released.

// File: rtl/clksel_div_pkg.sv
package clksel_div_pkg;

    // Registered state of the strobe generator
    typedef struct packed {
        logic act_pll;   // active source
        logic hs;        // high-speed strobe
        logic x2;        // double-rate strobe
        logic bus;       // 1x strobe
    } ckd_state_t;

    localparam ckd_state_t CKD_RESET = '{act_pll: 1'b0, hs: 1'b0, x2: 1'b0, bus: 1'b0};

endpackage

// File: rtl/clksel_divcnt.sv
module clksel_divcnt #(
    parameter int DIV = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv_i,
    output logic [$clog2(DIV)-1:0]     cnt_o,
    output logic                       wrap_o
);
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = adv_i && (cnt_q == LAST);
        if (adv_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(adv_i) |-> $stable(cnt_q));

endmodule

// File: rtl/clksel_gate.sv
module clksel_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_i,
    input  logic fast_i,
    input  logic fast_sel_i,
    input  logic stall_i,
    output logic en_o
);
    logic en_d, en_q;

    always_comb begin
        en_d = (fast_sel_i ? fast_i : slow_i) && !stall_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en_o = en_q;

    // R8
    stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> !$past(stall_i));

endmodule

// File: rtl/clksel_div.sv
module clksel_div
    import clksel_div_pkg::*;
#(
    parameter int N_PER  = 2,
    parameter int HS_DIV = 2,
    parameter int X2_DIV = 3,
    parameter int BUS_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             src_pll,
    input  logic             tmr_fast,
    input  logic             pwm_fast,
    input  logic             tmr_stall,
    input  logic             pwm_stall,
    input  logic [N_PER-1:0] per_stall,
    output logic             hs_en,
    output logic             x2_en,
    output logic             bus_en,
    output logic             tmr_en,
    output logic             pwm_en,
    output logic [N_PER-1:0] per_en
);
    localparam int HS_W  = $clog2(HS_DIV);
    localparam int X2_W  = $clog2(X2_DIV);
    localparam int BUS_W = $clog2(BUS_DIV);
    localparam int N_GATE = N_PER + 2;

    ckd_state_t st_d, st_q;

    logic [HS_W-1:0]  hs_cnt;
    logic [X2_W-1:0]  x2_cnt;
    logic [BUS_W-1:0] bus_cnt;
    logic hs_wrap, x2_wrap, bus_wrap;
    logic all_zero, pll_adv, x2_s;

    always_comb begin
        st_d     = st_q;
        all_zero = (hs_cnt == '0) && (x2_cnt == '0) && (bus_cnt == '0);
        if (all_zero && (src_pll != st_q.act_pll)) begin
            st_d.act_pll = src_pll;
        end
        pll_adv  = ref_tick && st_d.act_pll;
        x2_s     = st_d.act_pll ? x2_wrap : ref_tick;
        st_d.hs  = hs_wrap;
        st_d.x2  = x2_s;
        st_d.bus = bus_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CKD_RESET;
        else        st_q <= st_d;
    end

    clksel_divcnt #(.DIV(HS_DIV)) u_hs_cnt (
        .clk(clk), .rst_n(rst_n), .adv_i(pll_adv), .cnt_o(hs_cnt), .wrap_o(hs_wrap));

    clksel_divcnt #(.DIV(X2_DIV)) u_x2_cnt (
        .clk(clk), .rst_n(rst_n), .adv_i(pll_adv), .cnt_o(x2_cnt), .wrap_o(x2_wrap));

    clksel_divcnt #(.DIV(BUS_DIV)) u_bus_cnt (
        .clk(clk), .rst_n(rst_n), .adv_i(x2_s), .cnt_o(bus_cnt), .wrap_o(bus_wrap));

    // Gate slots: 0 = timer, 1 = PWM, 2.. = general peripherals
    logic [N_GATE-1:0] g_fast_sel, g_stall, g_en;

    assign g_fast_sel[0] = tmr_fast;
    assign g_fast_sel[1] = pwm_fast;
    assign g_stall[0]    = tmr_stall;
    assign g_stall[1]    = pwm_stall;

    genvar gi;
    generate
        for (gi = 0; gi < N_PER; gi++) begin : g_per_cfg
            assign g_fast_sel[gi+2] = 1'b0;
            assign g_stall[gi+2]    = per_stall[gi];
        end
        for (gi = 0; gi < N_GATE; gi++) begin : g_gate
            clksel_gate u_gate (
                .clk(clk), .rst_n(rst_n),
                .slow_i(bus_wrap), .fast_i(hs_wrap),
                .fast_sel_i(g_fast_sel[gi]), .stall_i(g_stall[gi]),
                .en_o(g_en[gi]));
        end
    endgenerate

    assign hs_en  = st_q.hs;
    assign x2_en  = st_q.x2;
    assign bus_en = st_q.bus;
    assign tmr_en = g_en[0];
    assign pwm_en = g_en[1];
    assign per_en = g_en[N_GATE-1:2];

    // R5
    hs_needs_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> st_q.act_pll);

    // R4
    bus_on_x2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> x2_en);

    // R6
    switch_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act_pll != $past(st_q.act_pll)) |-> $past(all_zero));

    // R10
    strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x2_en |-> $past(ref_tick));

endmodule

// File: tb/sim_clksel_div.sv
module sim_clksel_div;
    localparam int NP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 0, src_pll = 0, tmr_fast = 0, pwm_fast = 0;
    logic tmr_stall = 0, pwm_stall = 0;
    logic [NP-1:0] per_stall = '0;
    logic hs_en, x2_en, bus_en, tmr_en, pwm_en;
    logic [NP-1:0] per_en;

    int n_tests = 0;
    int n_fail = 0;

    // Reference model state
    int mode = 0;   // 0 oscillator, 1 PLL
    int ph_p = 0;   // PLL phase 0..5
    int ph_o = 0;   // oscillator phase 0..1
    bit e_hs = 0, e_x2 = 0, e_bus = 0, e_tmr = 0, e_pwm = 0;
    bit [NP-1:0] e_per = '0;

    bit cnt_on = 0;
    int c_hs = 0, c_bus = 0;

    always #2 clk = ~clk;

    clksel_div #(.N_PER(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .src_pll(src_pll),
        .tmr_fast(tmr_fast), .pwm_fast(pwm_fast), .tmr_stall(tmr_stall),
        .pwm_stall(pwm_stall), .per_stall(per_stall),
        .hs_en(hs_en), .x2_en(x2_en), .bus_en(bus_en),
        .tmr_en(tmr_en), .pwm_en(pwm_en), .per_en(per_en));

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 hs_en", hs_en, e_hs);
        chk("R3/R5 x2_en", x2_en, e_x2);
        chk("R4 bus_en", bus_en, e_bus);
        chk("R7/R8 tmr_en", tmr_en, e_tmr);
        chk("R7/R8 pwm_en", pwm_en, e_pwm);
        for (int i = 0; i < NP; i++) chk("R9 per_en", per_en[i], e_per[i]);
        if (cnt_on) begin
            c_hs  += hs_en;
            c_bus += bus_en;
        end
    endtask

    // Behavioural step: the strobes the next edge must produce (R10: one cycle later)
    task automatic model_step();
        bit zero, hs, x2, bus;
        zero = (mode == 1) ? (ph_p == 0) : (ph_o == 0);
        if (zero && (int'(src_pll) != mode)) mode = int'(src_pll);   // R6
        if (mode == 1) begin
            hs  = ref_tick && (ph_p % 2 == 1);
            x2  = ref_tick && (ph_p % 3 == 2);
            bus = ref_tick && (ph_p == 5);
            if (ref_tick) ph_p = (ph_p + 1) % 6;
        end else begin
            hs  = 0;
            x2  = ref_tick;
            bus = ref_tick && (ph_o == 1);
            if (ref_tick) ph_o = 1 - ph_o;
        end
        e_hs = hs; e_x2 = x2; e_bus = bus;
        e_tmr = (tmr_fast ? hs : bus) && !tmr_stall;
        e_pwm = (pwm_fast ? hs : bus) && !pwm_stall;
        for (int i = 0; i < NP; i++) e_per[i] = bus && !per_stall[i];
    endtask

    task automatic run(input int cyc, input int tick_pct, input bit sel,
                       input bit ft, input bit fp, input int stall_pct);
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            compare_all();
            ref_tick  = ($urandom_range(99) < tick_pct);
            src_pll   = sel;
            tmr_fast  = ft;
            pwm_fast  = fp;
            tmr_stall = ($urandom_range(99) < stall_pct);
            pwm_stall = ($urandom_range(99) < stall_pct);
            for (int i = 0; i < NP; i++) per_stall[i] = ($urandom_range(99) < stall_pct);
            model_step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs low while reset is held, even with activity on inputs
        ref_tick = 1; src_pll = 1; tmr_fast = 1;
        repeat (4) @(negedge clk);
        chk("R1 hs_en", hs_en, 0);
        chk("R1 x2_en", x2_en, 0);
        chk("R1 bus_en", bus_en, 0);
        chk("R1 tmr_en", tmr_en, 0);
        chk("R1 per_en", |per_en, 0);
        ref_tick = 0; src_pll = 0; tmr_fast = 0;
        rst_n = 1;

        run(40, 100, 0, 0, 0, 0);   // R5 oscillator, every tick
        run(60, 50, 0, 1, 0, 0);    // R5 random ticks, timer fast but no hs
        run(40, 100, 1, 0, 1, 0);   // R6 switch to PLL, R2/R3
        cnt_on = 1;
        run(60, 100, 1, 1, 0, 0);   // R4 ratio window
        cnt_on = 0;
        chk("R4 hs count", c_hs == 30, 1);
        chk("R4 bus count", c_bus == 10, 1);
        run(300, 60, 1, 1, 1, 30);  // R7/R8 random ticks and stalls
        run(200, 70, 0, 0, 1, 20);  // R6 switch back mid-phase
        for (int r = 0; r < 10; r++) begin
            run(37 + r, 80, r[0], r[1], r[2], 25);   // repeated source flips
        end
        run(100, 100, 1, 0, 0, 100); // R8 full stall, then release
        run(60, 100, 1, 1, 1, 0);
        @(negedge clk);
        compare_all();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule